// File: doc/BRIEF.md
# Half-Duplex Teletype Line Interfacer

This block is the glue between a serial teletype line, a character receiver and a character transmitter that share one free-running clock running at eight times the bit rate. The clock cannot be gated, so every start-stop decision is made inside the block with clock enables. The transmitter gets a fixed bit-rate enable. The receiver gets a sampling enable that is realigned to the start element of each incoming character.

A falling line (space, logic 0) counts as a start element only when it stays at space for half a bit unit. Shorter dips are treated as noise and discarded. Once a start is accepted, the block pulses the receiver enable near the middle of every data bit and of the stop element. For that whole stretch it holds the transmitter off, so the link behaves as half duplex. The receiver's flag can be cleared at once, or the clear can be armed and then take effect when the next valid start element arrives.

Top module: `tty_line_ctl`

## Requirements
- R1: On power clear (`pwr_clr` high at a clock edge), every output is low after that edge, the receive path is idle, any armed clear is dropped, and the transmit divider restarts from zero.
- R2: `tx_en` is high for exactly one cycle in every `OVS` cycles. The first pulse follows the `OVS`-th edge after power clear is released. The line and the clear requests have no effect on it.
- R3: A start element is accepted on the edge where `line_in` has been sampled at 0 (space) on `START_RUN` consecutive edges while idle (4 by default). A run of space samples shorter than this produces neither `tx_hold` nor `rx_en`.
- R4: `tx_hold` rises on the edge that accepts a start element. It stays high up to and including the cycle of the final `rx_en` pulse of that character, and is low at all other times.
- R5: After acceptance, `rx_en` is a single-cycle pulse every `OVS` cycles. The first pulse comes `OVS` edges after the accepting edge, and there are exactly `DATA_BITS`+1 pulses (data bits plus one stop sample). The block then returns to idle.
- R6: While a character is being received, `line_in` is ignored: neither pulses nor noise on the line change the timing or count of `rx_en`, nor `tx_hold`.
- R7: `clr_now` high at an edge makes `flag_clr` high for the following cycle.
- R8: `clr_at_start` high at an edge arms a deferred clear. `flag_clr` then pulses for one cycle on the edge that accepts the next start element, and the arming is used up. A request made at the accepting edge itself waits for the start after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock at OVS times the bit rate |
| pwr_clr | input | 1 | Synchronous power clear, active high |
| line_in | input | 1 | Serial line, 1 = mark, 0 = space |
| clr_now | input | 1 | Request an immediate receiver flag clear |
| clr_at_start | input | 1 | Request a receiver flag clear at the next start element |
| rx_en | output | 1 | Receiver sampling enable, one pulse per bit |
| tx_en | output | 1 | Transmitter bit-rate enable |
| tx_hold | output | 1 | Holds the transmitter while a character is received |
| flag_clr | output | 1 | Clears the receiver flag |

## Verification
The hardest cases to reach are the edges of the start filter: a space run exactly one sample too short, a run exactly long enough, and a deferred clear requested on the very edge that accepts a start. Random line segments are weighted toward short space runs around the threshold, and directed sequences produce the exact three- and four-sample runs. Other directed sequences toggle the line during reception and apply power clear in the middle of a character. A cycle model built from the requirements predicts every output on every cycle.

// File: rtl/tty_line_ctl.sv
module tty_line_ctl #(
  parameter int DATA_BITS = 8,
  parameter int OVS       = 8,
  parameter int START_RUN = 4
) (
  input  logic clk,
  input  logic pwr_clr,
  input  logic line_in,
  input  logic clr_now,
  input  logic clr_at_start,
  output logic rx_en,
  output logic tx_en,
  output logic tx_hold,
  output logic flag_clr
);
  localparam int PW = $clog2(OVS);
  localparam int BW = $clog2(DATA_BITS + 1);
  localparam int SW = $clog2(START_RUN + 1);

  typedef enum logic [1:0] {IDLE, CHECK, RECV} st_t;

  st_t           st;
  logic [PW-1:0] tx_div;
  logic [PW-1:0] phase;
  logic [BW-1:0] bits;
  logic [SW-1:0] run;
  logic          armed;

  wire space    = ~line_in;
  wire start_ok = (st == CHECK) && space && (run == SW'(START_RUN - 1));
  wire bit_tick = (st == RECV) && (phase == PW'(OVS - 1));
  wire last_bit = bit_tick && (bits == BW'(DATA_BITS));

  assign rx_en   = bit_tick;
  assign tx_hold = (st == RECV);
  assign tx_en   = (tx_div == PW'(OVS - 1));

  always_ff @(posedge clk) begin
    if (pwr_clr) tx_div <= '0;
    else         tx_div <= tx_en ? '0 : tx_div + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (pwr_clr) begin
      st    <= IDLE;
      run   <= '0;
      phase <= '0;
      bits  <= '0;
    end else begin
      case (st)
        IDLE: if (space) begin
          st  <= CHECK;
          run <= SW'(1);
        end
        CHECK: begin
          if (!space) begin
            st  <= IDLE;
            run <= '0;
          end else if (start_ok) begin
            st    <= RECV;
            run   <= '0;
            phase <= '0;
            bits  <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end
        RECV: begin
          phase <= (phase == PW'(OVS - 1)) ? '0 : phase + 1'b1;
          if (last_bit)      st   <= IDLE;
          else if (bit_tick) bits <= bits + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (pwr_clr) begin
      armed    <= 1'b0;
      flag_clr <= 1'b0;
    end else begin
      armed    <= clr_at_start | (armed & ~start_ok);
      flag_clr <= clr_now | (armed & start_ok);
    end
  end
endmodule

// File: rtl/tty_line_ctl_chk.sv
module tty_line_ctl_chk (
  input logic clk,
  input logic pwr_clr,
  input logic line_in,
  input logic clr_now,
  input logic clr_at_start,
  input logic rx_en,
  input logic tx_en,
  input logic tx_hold,
  input logic flag_clr
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    pwr_clr |=> (!rx_en && !tx_hold && !flag_clr && !tx_en));

  assert_tx_single_R2: assert property (@(posedge clk) disable iff (pwr_clr)
    tx_en |=> !tx_en);

  assert_start_run_R3: assert property (@(posedge clk) disable iff (pwr_clr)
    $rose(tx_hold) |-> (!$past(line_in, 1) && !$past(line_in, 2) &&
                        !$past(line_in, 3) && !$past(line_in, 4)));

  assert_enable_in_hold_R4: assert property (@(posedge clk) disable iff (pwr_clr)
    rx_en |-> tx_hold);

  assert_rx_single_R5: assert property (@(posedge clk) disable iff (pwr_clr)
    rx_en |=> !rx_en);

  assert_clear_now_R7: assert property (@(posedge clk) disable iff (pwr_clr)
    clr_now |=> flag_clr);
endmodule

bind tty_line_ctl tty_line_ctl_chk u_chk (.*);

// File: tb/sim_tty_line_ctl.sv
`timescale 1ns/1ps
module sim_tty_line_ctl;
  localparam int NB = 8;
  localparam int OV = 8;
  localparam int SR = 4;

  logic clk = 0, pwr_clr = 1, line_in = 1, clr_now = 0, clr_at_start = 0;
  logic rx_en, tx_en, tx_hold, flag_clr;

  tty_line_ctl #(.DATA_BITS(NB), .OVS(OV), .START_RUN(SR)) u0 (
    .clk(clk), .pwr_clr(pwr_clr), .line_in(line_in), .clr_now(clr_now),
    .clr_at_start(clr_at_start), .rx_en(rx_en), .tx_en(tx_en),
    .tx_hold(tx_hold), .flag_clr(flag_clr));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int m_tick = 0, m_run = 0, m_left = 0;
  bit m_armed = 0, m_flag = 0, m_acc = 0;

  function automatic bit exp_tx(int t);  return (t % OV) == OV - 1; endfunction
  function automatic bit exp_rx(int l);  return l > 0 && (l % OV) == 1; endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (pwr_clr) begin
      m_tick = 0; m_run = 0; m_left = 0; m_armed = 0; m_flag = 0; m_acc = 0;
    end else begin
      m_tick++;
      m_acc = 0;
      if (m_left > 0) m_left--;
      else if (!line_in) begin
        m_run++;
        if (m_run == SR) begin m_acc = 1; m_run = 0; m_left = OV * (NB + 1); end
      end else m_run = 0;
      m_flag  = clr_now | (m_armed & m_acc);
      m_armed = clr_at_start | (m_armed & ~m_acc);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic step(logic l, logic cn, logic cs);
    @(negedge clk);
    chk("R2 tx_en", tx_en, exp_tx(m_tick));
    chk("R5 rx_en", rx_en, exp_rx(m_left));
    chk("R4 tx_hold", tx_hold, m_left > 0);
    chk("R7/R8 flag_clr", flag_clr, m_flag);
    line_in = l; clr_now = cn; clr_at_start = cs;
  endtask

  task automatic do_reset();
    @(negedge clk); pwr_clr = 1;
    repeat (2) @(negedge clk);
    chk("R1 rx_en", rx_en, 0);
    chk("R1 tx_hold", tx_hold, 0);
    chk("R1 flag_clr", flag_clr, 0);
    chk("R1 tx_en", tx_en, 0);
    pwr_clr = 0;
  endtask

  int pulses;

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    repeat (20) step(1, 0, 0);
    // R3: three space samples then mark are rejected
    repeat (3) step(0, 0, 0);
    repeat (12) step(1, 0, 0);
    chk("R3 short run no hold", tx_hold, 0);
    // R3/R8: deferred clear armed, then exactly four spaces accepted
    step(1, 0, 1);
    step(1, 0, 0);
    repeat (4) step(0, 0, 0);
    step(1, 0, 0);
    chk("R3 accepted hold", tx_hold, 1);
    // R6: line toggles during reception; count rx_en pulses
    pulses = 0;
    for (int i = 0; i < OV * (NB + 1) + 4; i++) begin
      step(i[0], 0, 0);
      if (rx_en) pulses++;
    end
    chk("R5 R6 pulse count ok", pulses == NB + 1, 1);
    // R8: request on accepting edge waits for the following start
    repeat (4) step(1, 0, 0);
    repeat (3) step(0, 0, 0);
    step(0, 0, 1);
    repeat (80) step(1, 0, 0);
    repeat (4) step(0, 0, 0);
    repeat (80) step(1, 0, 0);
    // R7: immediate clear
    step(1, 1, 0);
    step(1, 0, 0);
    // R1: reset in mid reception
    repeat (4) step(0, 0, 0);
    repeat (20) step(1, 0, 0);
    do_reset();
    repeat (10) step(1, 0, 0);
    // random segments
    for (int s = 0; s < 600; s++) begin
      int kind = $urandom % 4;
      int len  = (kind == 0) ? 1 + $urandom % 5 : 1 + $urandom % 20;
      for (int j = 0; j < len; j++)
        step((kind == 0) ? 1'b0 : ((kind == 1) ? 1'($urandom % 2) : 1'b1),
             ($urandom % 23) == 0, ($urandom % 17) == 0);
    end
    repeat (100) step(1, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule